// File: doc/BRIEF.md
# Compare-Latch Branch Resolver

This block resolves conditional branches for a small 32-bit processor that has no condition flags. A compare instruction does not compute any flags. It stores both of its raw operands in two latches. A later conditional branch names one of ten relations. The block tests that relation against the stored pair at branch time and returns whether the branch is taken and which address comes next.

The decoder pulses the compare strobe with the two register values. It pulses the branch strobe with a 4-bit condition code, a 10-bit signed offset and the address of the branch. One clock later the block presents a one-cycle result. The result carries a taken flag, the next program counter and an illegal-condition flag. The block does not decode instructions, does not store the program counter and does not handle exceptions. It only reports the illegal flag to the logic that does.

Top module: `cmpbr_resolver`

## Requirements
- R1: After synchronous reset, res_valid, res_taken, res_illegal and res_next_pc are all zero. Both operand latches hold zero, so an equal-relation branch issued right after reset is taken.
- R2: A compare strobe captures cmp_a and cmp_b at their full 32-bit width. A later compare replaces both stored values.
- R3: The signed codes are: 2 (A < B), 3 (A > B), 6 (A >= B) and 7 (A <= B). Each treats the two stored values as two's complement numbers.
- R4: The unsigned codes are: 4 (A < B), 5 (A > B), 8 (A >= B) and 9 (A <= B).
- R5: Code 0 is taken when the stored values are equal. Code 1 is taken when they differ.
- R6: For a taken branch, res_next_pc is br_pc + 2 + (sign-extended br_off × 2).
- R7: For a legal branch that is not taken, res_next_pc is br_pc + 2.
- R8: Codes 10 to 15 are illegal. They set res_illegal, clear res_taken and return br_pc unchanged as res_next_pc.
- R9: When a compare and a branch arrive in the same cycle, the branch is evaluated on the values stored before that compare. The new values apply from the next branch onward.
- R10: All address arithmetic wraps modulo 2^32.
- R11: The result appears in the cycle after the branch strobe. res_valid is high for exactly that one cycle. With no branch strobe, res_next_pc, res_taken and res_illegal hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_en | input | 1 | Compare strobe |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand |
| br_en | input | 1 | Branch strobe |
| br_cond | input | 4 | Relation code |
| br_off | input | 10 | Signed half-word branch offset |
| br_pc | input | 32 | Address of the branch |
| res_valid | output | 1 | Result present this cycle |
| res_taken | output | 1 | Branch taken |
| res_illegal | output | 1 | Condition code not defined |
| res_next_pc | output | 32 | Next program counter |

## Verification
All ten legal codes are run against several stored pairs:
- An equal pair separates the strict relations from the inclusive ones.
- A pair whose first value has its top bit set, compared against a small positive value, makes every signed code disagree with its unsigned counterpart.
- An ordinary ascending pair and descending pair confirm the direction of each relation.

For the target address, the largest positive offset and the most negative offset both check the sign extension. Addresses next to 2^32 check the wrap. A compare issued in the same cycle as a branch shows whether the branch uses the old or the new values.

// File: rtl/cmpbr_pkg.sv
package cmpbr_pkg;

    localparam int DATA_W = 32;
    localparam int OFF_W  = 10;
    localparam int COND_W = 4;

    // Relation codes; the numbering is decoded by the instruction stream.
    typedef enum logic [COND_W-1:0] {
        REL_EQ  = 4'd0,
        REL_NE  = 4'd1,
        REL_SLT = 4'd2,
        REL_SGT = 4'd3,
        REL_ULT = 4'd4,
        REL_UGT = 4'd5,
        REL_SGE = 4'd6,
        REL_SLE = 4'd7,
        REL_UGE = 4'd8,
        REL_ULE = 4'd9
    } rel_e;

    localparam logic [COND_W-1:0] REL_LAST = REL_ULE;

    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
    } opnd_pair_t;

    typedef struct packed {
        logic              valid;
        logic              taken;
        logic              illegal;
        logic [DATA_W-1:0] next_pc;
    } br_res_t;

    function automatic logic cond_legal(input logic [COND_W-1:0] c);
        return c <= REL_LAST;
    endfunction

endpackage

// File: rtl/cmpbr_latch.sv
module cmpbr_latch
    import cmpbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output opnd_pair_t        pair
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pair <= '0;
        end else if (load) begin
            pair.a <= in_a;
            pair.b <= in_b;
        end
    end

    assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (pair.a == $past(in_a)) && (pair.b == $past(in_b)));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(pair));
endmodule

// File: rtl/cmpbr_rel.sv
module cmpbr_rel
    import cmpbr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0]      op_a,
    input  logic [W-1:0]      op_b,
    input  logic [COND_W-1:0] cond,
    output logic              hit,
    output logic              illegal
);
    logic eq, ult, slt;

    always_comb begin
        eq  = (op_a == op_b);
        ult = (op_a < op_b);
        slt = ($signed(op_a) < $signed(op_b));
    end

    always_comb begin
        illegal = 1'b0;
        case (cond)
            REL_EQ:  hit = eq;
            REL_NE:  hit = !eq;
            REL_SLT: hit = slt;
            REL_SGT: hit = !slt && !eq;
            REL_ULT: hit = ult;
            REL_UGT: hit = !ult && !eq;
            REL_SGE: hit = !slt;
            REL_SLE: hit = slt || eq;
            REL_UGE: hit = !ult;
            REL_ULE: hit = ult || eq;
            default: begin
                hit     = 1'b0;
                illegal = 1'b1;
            end
        endcase
    end

    always_comb begin
        assert_illegal_never_hits_R8: assert (!(illegal && hit));
    end
endmodule

// File: rtl/cmpbr_target.sv
module cmpbr_target
    import cmpbr_pkg::*;
#(
    parameter int W    = DATA_W,
    parameter int OW   = OFF_W,
    parameter int STEP = 2
) (
    input  logic [W-1:0]  pc,
    input  logic [OW-1:0] off,
    input  logic          taken,
    input  logic          illegal,
    output logic [W-1:0]  next_pc
);
    localparam int EXT_W = W - OW - 1;

    logic [W-1:0] disp;
    logic [W-1:0] seq_pc;

    always_comb begin
        disp    = {{EXT_W{off[OW-1]}}, off, 1'b0};
        seq_pc  = pc + W'(STEP);
        if (illegal)
            next_pc = pc;
        else if (taken)
            next_pc = seq_pc + disp;
        else
            next_pc = seq_pc;
    end
endmodule

// File: rtl/cmpbr_resolver.sv
module cmpbr_resolver
    import cmpbr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmp_en,
    input  logic [31:0] cmp_a,
    input  logic [31:0] cmp_b,
    input  logic        br_en,
    input  logic [3:0]  br_cond,
    input  logic [9:0]  br_off,
    input  logic [31:0] br_pc,
    output logic        res_valid,
    output logic        res_taken,
    output logic        res_illegal,
    output logic [31:0] res_next_pc
);
    opnd_pair_t        pair;
    logic              hit, bad;
    logic [DATA_W-1:0] tgt;
    br_res_t           res_q;

    cmpbr_latch u_latch (
        .clk  (clk),
        .rst  (rst),
        .load (cmp_en),
        .in_a (cmp_a),
        .in_b (cmp_b),
        .pair (pair)
    );

    cmpbr_rel #(.W(DATA_W)) u_rel (
        .op_a    (pair.a),
        .op_b    (pair.b),
        .cond    (br_cond),
        .hit     (hit),
        .illegal (bad)
    );

    cmpbr_target #(.W(DATA_W), .OW(OFF_W)) u_target (
        .pc      (br_pc),
        .off     (br_off),
        .taken   (hit),
        .illegal (bad),
        .next_pc (tgt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.valid <= br_en;
            if (br_en) begin
                res_q.taken   <= hit;
                res_q.illegal <= bad;
                res_q.next_pc <= tgt;
            end
        end
    end

    assign res_valid   = res_q.valid;
    assign res_taken   = res_q.taken;
    assign res_illegal = res_q.illegal;
    assign res_next_pc = res_q.next_pc;

    assert_illegal_keeps_pc_R8: assert property (@(posedge clk) disable iff (rst)
        (br_en && !cond_legal(br_cond)) |=>
            (res_illegal && !res_taken && res_next_pc == $past(br_pc)));

    assert_fallthrough_R7: assert property (@(posedge clk) disable iff (rst)
        (br_en && cond_legal(br_cond)) |=>
            (!res_illegal && (res_taken || res_next_pc == $past(br_pc) + 32'd2)));

    assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        br_en |=> res_valid);

    assert_no_spurious_R11: assert property (@(posedge clk) disable iff (rst)
        !br_en |=> (!res_valid && $stable(res_next_pc) && $stable(res_taken)));
endmodule

// File: tb/cmpbr_resolver_bench.sv
module cmpbr_resolver_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmp_en;
    logic [31:0] cmp_a, cmp_b;
    logic        br_en;
    logic [3:0]  br_cond;
    logic [9:0]  br_off;
    logic [31:0] br_pc;
    logic        res_valid, res_taken, res_illegal;
    logic [31:0] res_next_pc;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [31:0] mdl_a = '0;
    logic [31:0] mdl_b = '0;

    always #2 clk = ~clk;

    cmpbr_resolver u_cmpbr_resolver (
        .clk(clk), .rst(rst),
        .cmp_en(cmp_en), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .br_en(br_en), .br_cond(br_cond), .br_off(br_off), .br_pc(br_pc),
        .res_valid(res_valid), .res_taken(res_taken),
        .res_illegal(res_illegal), .res_next_pc(res_next_pc)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit rel_ref(int c, logic [31:0] a, logic [31:0] b);
        case (c)
            0: return a == b;
            1: return a != b;
            2: return $signed(a) <  $signed(b);
            3: return $signed(a) >  $signed(b);
            4: return a <  b;
            5: return a >  b;
            6: return $signed(a) >= $signed(b);
            7: return $signed(a) <= $signed(b);
            8: return a >= b;
            9: return a <= b;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] off_ref(logic [9:0] o);
        int s = $signed(o);
        return 32'(s * 2);
    endfunction

    task automatic do_cmp(logic [31:0] a, logic [31:0] b);
        @(negedge clk);
        cmp_en = 1'b1; cmp_a = a; cmp_b = b;
        @(negedge clk);
        cmp_en = 1'b0;
        mdl_a = a; mdl_b = b;
    endtask

    // Issues a branch and checks the result one cycle later.
    task automatic do_br(string req, int c, logic [9:0] o, logic [31:0] pc);
        bit          t, ill;
        logic [31:0] nxt;
        @(negedge clk);
        br_en = 1'b1; br_cond = 4'(c); br_off = o; br_pc = pc;
        @(negedge clk);
        br_en = 1'b0;
        ill = (c > 9);
        t   = rel_ref(c, mdl_a, mdl_b);
        nxt = ill ? pc : (t ? pc + 32'd2 + off_ref(o) : pc + 32'd2);
        check(req, "valid",   32'(res_valid),   32'd1);
        check(req, "taken",   32'(res_taken),   32'(t));
        check(req, "illegal", 32'(res_illegal), 32'(ill));
        check(req, "next_pc", res_next_pc, nxt);
    endtask

    task automatic t_reset_R1();
        check("R1", "valid",   32'(res_valid),   32'd0);
        check("R1", "taken",   32'(res_taken),   32'd0);
        check("R1", "illegal", 32'(res_illegal), 32'd0);
        check("R1", "next_pc", res_next_pc, 32'd0);
        do_br("R1", 0, 10'd3, 32'h0000_0100);
    endtask

    task automatic t_all_codes(string req, logic [31:0] a, logic [31:0] b);
        do_cmp(a, b);
        for (int c = 0; c < 10; c++) do_br(req, c, 10'd8, 32'h0000_2000);
    endtask

    task automatic t_latch_R2();
        do_cmp(32'hA5A5_0000, 32'h0000_5A5A);
        do_br("R2", 5, 10'd1, 32'h40);
        do_cmp(32'h0000_0001, 32'h8000_0000);
        do_br("R2", 4, 10'd1, 32'h40);
        do_br("R2", 3, 10'd1, 32'h40);
    endtask

    task automatic t_offsets_R6();
        do_cmp(32'd7, 32'd7);
        do_br("R6", 0, 10'h1FF, 32'h0001_0000);
        do_br("R6", 0, 10'h200, 32'h0001_0000);
        do_br("R6", 0, 10'h3FF, 32'h0001_0000);
        check("R6", "neg-target", res_next_pc, 32'h0001_0000);
    endtask

    task automatic t_not_taken_R7();
        do_cmp(32'd1, 32'd2);
        do_br("R7", 0, 10'h155, 32'h0000_0ABC);
        do_br("R7", 5, 10'h0AA, 32'h0000_1234);
    endtask

    task automatic t_illegal_R8();
        do_cmp(32'd9, 32'd9);
        for (int c = 10; c < 16; c++) do_br("R8", c, 10'h010, 32'h0000_3000 + 32'(c));
    endtask

    task automatic t_same_cycle_R9();
        do_cmp(32'd5, 32'd5);
        @(negedge clk);
        cmp_en = 1'b1; cmp_a = 32'd1; cmp_b = 32'd9;
        br_en = 1'b1; br_cond = 4'd0; br_off = 10'd4; br_pc = 32'h500;
        @(negedge clk);
        cmp_en = 1'b0; br_en = 1'b0;
        check("R9", "old-values taken", 32'(res_taken), 32'd1);
        check("R9", "old-values next_pc", res_next_pc, 32'h50A);
        mdl_a = 32'd1; mdl_b = 32'd9;
        do_br("R9", 0, 10'd4, 32'h500);
    endtask

    task automatic t_wrap_R10();
        do_cmp(32'd0, 32'd1);
        do_br("R10", 0, 10'd0, 32'hFFFF_FFFE);
        check("R10", "fall wrap", res_next_pc, 32'h0000_0000);
        do_br("R10", 4, 10'd1, 32'hFFFF_FFFE);
        check("R10", "fwd wrap", res_next_pc, 32'h0000_0002);
        do_br("R10", 4, 10'h3FC, 32'h0000_0002);
        check("R10", "back wrap", res_next_pc, 32'hFFFF_FFFC);
    endtask

    task automatic t_hold_R11();
        logic [31:0] last;
        do_cmp(32'd3, 32'd4);
        do_br("R11", 4, 10'd6, 32'h800);
        last = res_next_pc;
        @(negedge clk);
        check("R11", "valid drop", 32'(res_valid), 32'd0);
        check("R11", "pc hold",    res_next_pc, last);
        check("R11", "taken hold", 32'(res_taken), 32'd1);
    endtask

    initial begin
        rst = 1'b1; cmp_en = 1'b0; br_en = 1'b0;
        cmp_a = '0; cmp_b = '0; br_cond = '0; br_off = '0; br_pc = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_R1();
        t_latch_R2();
        t_all_codes("R5", 32'h1234_5678, 32'h1234_5678);
        t_all_codes("R3", 32'hFFFF_FFFF, 32'h0000_0001);
        t_all_codes("R4", 32'h0000_0010, 32'h0000_0020);
        t_all_codes("R4", 32'h8000_0000, 32'h7FFF_FFFF);
        t_offsets_R6();
        t_not_taken_R7();
        t_illegal_R8();
        t_same_cycle_R9();
        t_wrap_R10();
        t_hold_R11();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule